// File: doc/BRIEF.md
# Self-Sizing Signed Displacement Decoder

This block takes an instruction byte stream, one byte per cycle over a valid/ready handshake, and turns one displacement field into a 32-bit two's-complement value. The first byte of the field tells the decoder how long the field is. If its top bit is 0, the field is one byte long. If the top two bits are 10, the field is two bytes long. If they are 11, the field is four bytes long. The remaining bytes arrive most significant first. The decoder removes the prefix bits, joins the payload, and sign-extends it.

A start strobe travels with the leading byte of each field. The decoder handles exactly one field per strobe and then goes back to idle. The result sits in a single registered output slot with its own valid/ready handshake. That slot reports the value and the field length in bytes. While the slot is full and the consumer is stalling, no input is taken. A start strobe that arrives in the middle of a multi-byte field is a protocol violation. The decoder ignores it and records it in a sticky error flag.

Top module: `disp_decoder`

## Requirements
- R1: A leading byte with bit 7 = 0 is a complete one-byte field. Its bits 6..0 form a 7-bit signed value, and out_len is 1.
- R2: A leading byte with bits 7..6 = 10 starts a two-byte field. Bits 5..0 of the leading byte are the upper payload bits and the next byte is the lower 8 bits, giving a 14-bit signed value. out_len is 2.
- R3: A leading byte with bits 7..6 = 11 starts a four-byte field. Bits 5..0 of the leading byte are followed by three more bytes, most significant first, giving a 30-bit signed value. out_len is 4.
- R4: The payload sign bit (bit 6, 13 or 29) is copied into every higher bit of the 32-bit out_value. out_len only ever takes the values 1, 2 or 4 while out_valid is high.
- R5: out_valid rises on the clock edge that accepts the final byte of a field, never earlier.
- R6: While out_valid is high and out_ready is low, in_ready is low, and out_value and out_len hold steady.
- R7: A start strobe on a byte accepted during an unfinished multi-byte field does not restart decoding. The byte is still used as payload, and proto_err is set. proto_err then stays high until reset.
- R8: A byte accepted while idle without a start strobe is discarded and produces no result.
- R9: Synchronous active-high rst empties the output slot, abandons any partial field and clears proto_err. After reset, in_ready is high.
- R10: When the slot is emptied (out_valid and out_ready) on the same edge that the final byte of a new field is accepted, the new result takes the slot with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Marks the byte on in_byte as the first of a field |
| in_valid | input | 1 | in_byte holds a byte |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| out_valid | output | 1 | Result slot full |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | 32 | Sign-extended displacement |
| out_len | output | 3 | Field length in bytes: 1, 2 or 4 |
| proto_err | output | 1 | Sticky flag for a start strobe inside a field |

## Verification
Two operations can land on one clock edge: draining the result slot and loading it with a newly completed field. The bench creates this overlap by holding a result while a start byte waits at the input. It then raises out_ready for exactly one cycle, so the pop and the acceptance of the waiting byte happen on the same edge. The case passes if out_valid stays high on the next cycle and the new value and length have replaced the old ones. The stall cycles before that edge are also checked: in_ready must stay low and the held result must not change.

// File: rtl/disp_decoder.sv
module disp_decoder (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_value,
  output logic [2:0]  out_len,
  output logic        proto_err
);
  localparam int PAY_W = 6;
  localparam int ACC_W = PAY_W + 16;

  logic             busy_q;
  logic [1:0]       left_q;
  logic [2:0]       len_q;
  logic [ACC_W-1:0] acc_q;
  logic             vld_q;
  logic [31:0]      val_q;
  logic [2:0]       olen_q;
  logic             err_q;

  wire take = in_valid && in_ready;
  wire pop  = vld_q && out_ready;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_value = val_q;
  assign out_len   = olen_q;
  assign proto_err = err_q;

  wire [13:0] f2 = {acc_q[PAY_W-1:0], in_byte};
  wire [29:0] f4 = {acc_q[ACC_W-1:0], in_byte};
  wire [31:0] v1 = {{25{in_byte[6]}}, in_byte[6:0]};
  wire [31:0] v2 = {{18{f2[13]}}, f2};
  wire [31:0] v4 = {{2{f4[29]}}, f4};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      left_q <= '0;
      len_q  <= '0;
      acc_q  <= '0;
      vld_q  <= 1'b0;
      val_q  <= '0;
      olen_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (pop) vld_q <= 1'b0;
      if (take) begin
        if (!busy_q) begin
          if (start) begin
            if (!in_byte[7]) begin
              vld_q  <= 1'b1;
              val_q  <= v1;
              olen_q <= 3'd1;
            end else begin
              busy_q <= 1'b1;
              acc_q  <= {{(ACC_W-PAY_W){1'b0}}, in_byte[PAY_W-1:0]};
              left_q <= in_byte[6] ? 2'd3 : 2'd1;
              len_q  <= in_byte[6] ? 3'd4 : 3'd2;
            end
          end
        end else begin
          if (start) err_q <= 1'b1;
          left_q <= left_q - 2'd1;
          if (left_q == 2'd1) begin
            busy_q <= 1'b0;
            vld_q  <= 1'b1;
            val_q  <= (len_q == 3'd2) ? v2 : v4;
            olen_q <= len_q;
            acc_q  <= '0;
          end else begin
            acc_q <= {acc_q[ACC_W-9:0], in_byte};
          end
        end
      end
    end
  end
endmodule

// File: rtl/disp_decoder_chk.sv
module disp_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_value,
  input logic [2:0]  out_len,
  input logic        proto_err
);
  // R1
  one_byte_sext_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == 3'd1 |-> out_value[31:6] == {26{out_value[6]}});
  // R4
  len_legal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len == 3'd1 || out_len == 3'd2 || out_len == 3'd4));
  // R5
  rise_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));
  // R6
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_len));
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !proto_err && in_ready);
endmodule

bind disp_decoder disp_decoder_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_value(out_value),
  .out_len(out_len), .proto_err(proto_err)
);

// File: tb/sim_disp_decoder.sv
`timescale 1ns/1ps
module sim_disp_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_value;
  logic [2:0]  out_len;
  logic        proto_err;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  disp_decoder u0 (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_len(out_len), .proto_err(proto_err)
  );

  // bytes(32, first byte on top) | count(3) | value(32) | len(3)
  localparam logic [69:0] VEC [13] = '{
    {32'h05000000, 3'd1, 32'h00000005, 3'd1},
    {32'h40000000, 3'd1, 32'hFFFFFFC0, 3'd1},
    {32'h7F000000, 3'd1, 32'hFFFFFFFF, 3'd1},
    {32'h3F000000, 3'd1, 32'h0000003F, 3'd1},
    {32'h80010000, 3'd2, 32'h00000001, 3'd2},
    {32'h9FFF0000, 3'd2, 32'h00001FFF, 3'd2},
    {32'hA0000000, 3'd2, 32'hFFFFE000, 3'd2},
    {32'hBFFF0000, 3'd2, 32'hFFFFFFFF, 3'd2},
    {32'hC0000100, 3'd4, 32'h00000100, 3'd4},
    {32'hDFFFFFFF, 3'd4, 32'h1FFFFFFF, 3'd4},
    {32'hE0000000, 3'd4, 32'hE0000000, 3'd4},
    {32'hFFFFFFFE, 3'd4, 32'hFFFFFFFE, 3'd4},
    {32'hC1234567, 3'd4, 32'h01234567, 3'd4}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic st);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; start = st;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0; start = 1'b0;
  endtask

  task automatic pop_result;
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!out_valid && in_ready && !proto_err, "R9", {29'd0, out_valid, in_ready, proto_err}, 32'h2);

    for (int i = 0; i < 13; i++) begin
      logic [31:0] bytes;
      int n;
      bytes = VEC[i][69:38];
      n = int'(VEC[i][37:35]);
      for (int k = 0; k < n; k++) begin
        push(bytes[31-8*k -: 8], k == 0);
        if (k < n - 1) begin
          @(negedge clk);
          // R5 no result before last byte
          chk(!out_valid, "R5", {31'd0, out_valid}, 32'd0);
        end
      end
      @(negedge clk);
      // R1 R2 R3 R4 value and length
      chk(out_valid && out_value == VEC[i][34:3],
          (n == 1) ? "R1/R4" : (n == 2) ? "R2/R4" : "R3/R4", out_value, VEC[i][34:3]);
      chk(out_len == VEC[i][2:0], "R4 len", {29'd0, out_len}, {29'd0, VEC[i][2:0]});
      pop_result();
      chk(!out_valid, "R6 pop", {31'd0, out_valid}, 32'd0);
    end

    // R8 byte without start in idle is discarded
    push(8'h05, 1'b0);
    @(negedge clk);
    chk(!out_valid, "R8", {31'd0, out_valid}, 32'd0);

    // R6 stall, then R10 pop and load on the same edge
    push(8'h05, 1'b1);
    @(negedge clk);
    in_valid = 1'b1; in_byte = 8'h06; start = 1'b1;
    for (int c = 0; c < 3; c++) begin
      chk(!in_ready, "R6 ready", {31'd0, in_ready}, 32'd0);
      chk(out_valid && out_value == 32'h5, "R6 hold", out_value, 32'h5);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0; start = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid && out_value == 32'h6 && out_len == 3'd1, "R10", out_value, 32'h6);
    pop_result();
    chk(!out_valid, "R10 drained", {31'd0, out_valid}, 32'd0);

    // R7 start strobe inside a four-byte field
    push(8'hC0, 1'b1);
    push(8'h00, 1'b1);
    @(negedge clk);
    chk(proto_err && !out_valid, "R7 flag", {30'd0, proto_err, out_valid}, 32'h2);
    push(8'h00, 1'b0);
    push(8'h05, 1'b0);
    @(negedge clk);
    chk(out_valid && out_value == 32'h5 && out_len == 3'd4, "R7 ignored", out_value, 32'h5);
    pop_result();
    push(8'h81, 1'b1);
    push(8'h00, 1'b0);
    @(negedge clk);
    chk(proto_err && out_value == 32'h100, "R7 sticky", out_value, 32'h100);
    pop_result();

    // R9 reset mid-field clears everything
    push(8'hC0, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!proto_err && !out_valid && in_ready, "R9 after", {29'd0, out_valid, in_ready, proto_err}, 32'h2);
    push(8'h02, 1'b0);
    @(negedge clk);
    chk(!out_valid, "R9 field dropped", {31'd0, out_valid}, 32'd0);
    push(8'h7E, 1'b1);
    @(negedge clk);
    chk(out_valid && out_value == 32'hFFFFFFFE, "R1 after reset", out_value, 32'hFFFFFFFE);

    finish_run();
  end
endmodule